// File: doc/BRIEF.md
# One-Bit Phase Detector Loop Controller

This block is the digital core of a fractional-N synthesizer whose phase detector is a single sampling flip-flop. Once per reference cycle it takes that flip-flop's early/late bit and turns it into a signed step of fixed size. The step is added to the fractional divide word ahead of a second-order noise-shaping modulator. This closes a fast inner loop that holds the divided clock within one step of the reference. The modulator's shaped quantization noise also acts as dither for the one-bit decision.

The same step drives a saturating digital integrator. A programmable outer-loop gain scales the integrator value, and the result is the wide oscillator control word that a DAC consumes. The step size, the outer gain and the divide word are runtime inputs. The step size and the gain are fractions with 16 fractional bits. The divide word has 4 integer and 16 fractional bits. The integer divide value sent to the divider is clamped to the range 8 to 15.

Top module: `pml_loop_ctrl`

## Requirements
- R1: The phase bit passes through two synchronizing flops. The bit captured at a clock edge becomes the decision used two edges later.
- R2: A decision of 1 gives a step of +alpha_i and a decision of 0 gives a step of -alpha_i. alpha_i is an unsigned fraction in units of 2^-16.
- R3: The modulator input is frac_word_i + step, with frac_word_i being unsigned with 16 fractional bits. Its integer part is the floor of that sum and its fraction is the low 16 bits.
- R4: The modulator is a cascade of two 16-bit accumulators. a1 += fraction, with carry c1. a2 += new a1, with carry c2. The raw divide value is integer + c1 + c2 - (c2 of the previous cycle), and it is registered into div_o.
- R5: div_o is always between 8 and 15 inclusive. A raw value below 8 gives 8 and a raw value above 15 gives 15.
- R6: The integrator adds the current step once per clock.
- R7: The integrator saturates at its signed maximum and minimum and does not wrap. Further steps in the same direction leave it unchanged.
- R8: osc_ctrl_o is registered from the pre-update integrator value times gain_i, shifted right arithmetically by 16 (floor).
- R9: Reset clears the synchronizer, the accumulators and the integrator. During reset div_o reads 12 and osc_ctrl_o reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| phase_bit_i | input | 1 | Early/late bit from the sampling flip-flop |
| frac_word_i | input | 20 | Divide word, 4 integer and 16 fractional bits |
| alpha_i | input | 16 | Quantizer step size, fraction of one divider unit |
| gain_i | input | 16 | Outer-loop gain, fraction |
| div_o | output | 4 | Integer divide value for the divider |
| osc_ctrl_o | output | 24 | Signed oscillator control word |

## Verification
A corrupted accumulator in the modulator changes the sequence of divide values within a cycle or two. This is visible even when the average divide value is still correct. A bench model that tracks div_o every clock therefore catches it. A wrong integrator state or a wrong saturation shows up on osc_ctrl_o one clock later, scaled by the gain. A wrong synchronizer depth shifts the response to every bit by one cycle, and both outputs reveal it.

// File: rtl/pml_pkg.sv
package pml_pkg;
  localparam int FRAC_W = 16;
  localparam int STEP_W = FRAC_W + 2;
  typedef logic signed [STEP_W-1:0] step_t;
endpackage

// File: rtl/pml_sync.sv
module pml_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic s1_q, s2_q;
  logic [1:0] warm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      warm_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
      if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end
  end

  assign q_o = s2_q;

  assert_sync_lat_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd2) |-> (q_o == $past(d_i, 2)));
endmodule

// File: rtl/pml_mash.sv
module pml_mash
  import pml_pkg::*;
#(
  parameter int WORD_W  = 20,
  parameter int DIV_W   = 4,
  parameter int DIV_MIN = 8,
  parameter int DIV_MAX = 15,
  parameter int DIV_RST = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  input  step_t             step_i,
  output logic [DIV_W-1:0]  div_o
);
  localparam int TOT_W = WORD_W + 2;
  localparam int INT_W = TOT_W - FRAC_W;
  localparam int RAW_W = INT_W + 2;
  localparam logic signed [RAW_W-1:0] RMIN = RAW_W'(DIV_MIN);
  localparam logic signed [RAW_W-1:0] RMAX = RAW_W'(DIV_MAX);

  logic signed [TOT_W-1:0] total;
  logic signed [INT_W-1:0] int_part;
  logic [FRAC_W-1:0]       frac;
  logic [FRAC_W-1:0]       a1_q, a2_q;
  logic                    c2_q;
  logic [FRAC_W:0]         sum1, sum2;
  logic signed [2:0]       c_net;
  logic signed [RAW_W-1:0] raw;
  logic [DIV_W-1:0]        div_d;

  assign total    = $signed({2'b00, word_i}) + TOT_W'(step_i);
  assign int_part = total[TOT_W-1:FRAC_W];
  assign frac     = total[FRAC_W-1:0];
  assign sum1     = {1'b0, a1_q} + {1'b0, frac};
  assign sum2     = {1'b0, a2_q} + {1'b0, sum1[FRAC_W-1:0]};
  assign c_net    = $signed({2'b00, sum1[FRAC_W]}) + $signed({2'b00, sum2[FRAC_W]})
                  - $signed({2'b00, c2_q});
  assign raw      = RAW_W'(int_part) + RAW_W'(c_net);

  always_comb begin
    if (raw < RMIN)      div_d = DIV_W'(DIV_MIN);
    else if (raw > RMAX) div_d = DIV_W'(DIV_MAX);
    else                 div_d = raw[DIV_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a1_q  <= '0;
      a2_q  <= '0;
      c2_q  <= 1'b0;
      div_o <= DIV_W'(DIV_RST);
    end else begin
      a1_q  <= sum1[FRAC_W-1:0];
      a2_q  <= sum2[FRAC_W-1:0];
      c2_q  <= sum2[FRAC_W];
      div_o <= div_d;
    end
  end

  assert_div_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_o >= DIV_W'(DIV_MIN)) && (div_o <= DIV_W'(DIV_MAX)));
endmodule

// File: rtl/pml_integ.sv
module pml_integ
  import pml_pkg::*;
#(
  parameter int ACC_W = 24
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  step_t                   step_i,
  input  logic [FRAC_W-1:0]       gain_i,
  output logic signed [ACC_W-1:0] osc_o
);
  localparam int PROD_W = ACC_W + FRAC_W + 1;
  localparam logic signed [ACC_W:0] MAXV = {2'b00, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W:0] MINV = {2'b11, {(ACC_W-1){1'b0}}};

  logic signed [ACC_W-1:0]  acc_q;
  logic signed [ACC_W:0]    sum;
  logic signed [ACC_W-1:0]  acc_d;
  logic signed [PROD_W-1:0] prod, shifted;

  assign sum = $signed({acc_q[ACC_W-1], acc_q}) + (ACC_W+1)'(step_i);

  always_comb begin
    if (sum > MAXV)      acc_d = MAXV[ACC_W-1:0];
    else if (sum < MINV) acc_d = MINV[ACC_W-1:0];
    else                 acc_d = sum[ACC_W-1:0];
  end

  assign prod    = acc_q * $signed({1'b0, gain_i});
  assign shifted = prod >>> FRAC_W;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      osc_o <= '0;
    end else begin
      acc_q <= acc_d;
      osc_o <= shifted[ACC_W-1:0];
    end
  end

  assert_sat_high_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_q == MAXV[ACC_W-1:0] && step_i >= 0) |=> (acc_q == MAXV[ACC_W-1:0]));
  assert_sat_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_q == MINV[ACC_W-1:0] && step_i <= 0) |=> (acc_q == MINV[ACC_W-1:0]));
  assert_dir_up_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i > 0) |=> (acc_q >= $past(acc_q)));
  assert_no_trunc_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shifted[PROD_W-1:ACC_W-1] == '0) || (shifted[PROD_W-1:ACC_W-1] == '1));
endmodule

// File: rtl/pml_loop_ctrl.sv
module pml_loop_ctrl
  import pml_pkg::*;
#(
  parameter int WORD_W  = 20,
  parameter int ACC_W   = 24,
  parameter int DIV_W   = 4,
  parameter int DIV_MIN = 8,
  parameter int DIV_MAX = 15,
  parameter int DIV_RST = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    phase_bit_i,
  input  logic [WORD_W-1:0]       frac_word_i,
  input  logic [FRAC_W-1:0]       alpha_i,
  input  logic [FRAC_W-1:0]       gain_i,
  output logic [DIV_W-1:0]        div_o,
  output logic signed [ACC_W-1:0] osc_ctrl_o
);
  logic  dec;
  step_t step;

  pml_sync u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (phase_bit_i),
    .q_o   (dec)
  );

  assign step = dec ? $signed({2'b00, alpha_i}) : -$signed({2'b00, alpha_i});

  pml_mash #(
    .WORD_W (WORD_W),
    .DIV_W  (DIV_W),
    .DIV_MIN(DIV_MIN),
    .DIV_MAX(DIV_MAX),
    .DIV_RST(DIV_RST)
  ) u_mash (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .word_i(frac_word_i),
    .step_i(step),
    .div_o (div_o)
  );

  pml_integ #(
    .ACC_W(ACC_W)
  ) u_integ (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_i(step),
    .gain_i(gain_i),
    .osc_o (osc_ctrl_o)
  );
endmodule

// File: tb/pml_loop_ctrl_bench.sv
module pml_loop_ctrl_bench;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic phase_bit_i = 1'b0;
  logic [19:0] frac_word_i = '0;
  logic [15:0] alpha_i = '0;
  logic [15:0] gain_i = '0;
  logic [3:0] div_o;
  logic signed [23:0] osc_ctrl_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  string cur_req = "R9";

  longint m_s1, m_s2, m_a1, m_a2, m_c2, m_int, m_osc, m_div;
  localparam longint IMAX = (64'sd1 <<< 23) - 1;
  localparam longint IMIN = -(64'sd1 <<< 23);

  always #5 clk_i = ~clk_i;

  pml_loop_ctrl u_pml_loop_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .phase_bit_i(phase_bit_i),
    .frac_word_i(frac_word_i), .alpha_i(alpha_i), .gain_i(gain_i),
    .div_o(div_o), .osc_ctrl_o(osc_ctrl_o)
  );

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference, updated per clock
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_s1 = 0; m_s2 = 0; m_a1 = 0; m_a2 = 0; m_c2 = 0;
      m_int = 0; m_osc = 0; m_div = 12;
    end else begin
      longint st, tot, ip, f, s1, s2, c1, c2, raw, nx;
      st  = m_s2 ? longint'(alpha_i) : -longint'(alpha_i);
      tot = longint'(frac_word_i) + st;
      ip  = tot >>> 16;
      f   = tot & 64'hFFFF;
      s1  = m_a1 + f;        c1 = s1 >> 16;
      s2  = m_a2 + (s1 & 64'hFFFF); c2 = s2 >> 16;
      raw = ip + c1 + c2 - m_c2;
      m_div = raw < 8 ? 8 : (raw > 15 ? 15 : raw);
      m_a1 = s1 & 64'hFFFF; m_a2 = s2 & 64'hFFFF; m_c2 = c2;
      m_osc = (m_int * longint'(gain_i)) >>> 16;
      nx = m_int + st;
      m_int = nx > IMAX ? IMAX : (nx < IMIN ? IMIN : nx);
      m_s2 = m_s1; m_s1 = longint'(phase_bit_i);
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      check({cur_req, " div_o"}, longint'(div_o), m_div);
      check({cur_req, " osc_ctrl_o"}, longint'(osc_ctrl_o), m_osc);
    end
  end

  task automatic run(int n, int mode);
    // mode 0 hold, 1 alternate, 2 random
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      if (mode == 1) phase_bit_i = ~phase_bit_i;
      else if (mode == 2) phase_bit_i = 1'($urandom_range(0, 1));
    end
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(7));
    repeat (3) @(negedge clk_i);
    check("R9 reset div_o", longint'(div_o), 12);
    check("R9 reset osc_ctrl_o", longint'(osc_ctrl_o), 0);
    rst_ni = 1'b1;

    // R3 R4: zero step, fractional word 12.5, then 12.08
    cur_req = "R3/R4"; frac_word_i = 20'hC8000; gain_i = 16'd1638;
    run(40, 0);
    frac_word_i = 20'hC147B; run(60, 0);

    // R1 R2 R6 R8: nominal alpha, alternating then random decisions
    cur_req = "R1/R2/R6/R8"; alpha_i = 16'd655;
    run(50, 1);
    run(300, 2);
    alpha_i = 16'h4000; gain_i = 16'h8000; run(200, 2);

    // R5: clamp high, raw value 16 and above
    cur_req = "R5"; frac_word_i = 20'hFF000; alpha_i = 16'hFFFF; phase_bit_i = 1'b1;
    run(10, 0);
    check("R5 clamp high", longint'(div_o), 15);
    frac_word_i = 20'h80000; phase_bit_i = 1'b0; run(4, 0);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk_i);
      check("R5 clamp low range", longint'(div_o >= 4'd8), 1);
    end

    // R7: saturation high then low
    cur_req = "R7"; frac_word_i = 20'hC0000; gain_i = 16'hFFFF; phase_bit_i = 1'b1;
    run(400, 0);
    check("R7 sat high", longint'(osc_ctrl_o), (IMAX * 65535) >>> 16);
    run(20, 0);
    check("R7 sat high hold", longint'(osc_ctrl_o), (IMAX * 65535) >>> 16);
    phase_bit_i = 1'b0; run(600, 0);
    check("R7 sat low", longint'(osc_ctrl_o), (IMIN * 65535) >>> 16);
    run(20, 0);
    check("R7 sat low hold", longint'(osc_ctrl_o), (IMIN * 65535) >>> 16);

    // R9: reset mid-run
    cur_req = "R9";
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i);
    check("R9 rerun div_o", longint'(div_o), 12);
    check("R9 rerun osc_ctrl_o", longint'(osc_ctrl_o), 0);
    rst_ni = 1'b1; alpha_i = 16'd655; gain_i = 16'd1638; frac_word_i = 20'hC147B;
    cur_req = "R1/R4/R9"; run(100, 2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule